// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block turns parallel words written by a host into a serial bit stream. An external frame sync marks where each frame begins. Everything advances on a bit-clock enable (`bit_en`) that is sampled in the system clock domain. A frame has one or two phases. Each phase has its own word length and its own word count. The first data bit can leave on the same bit period as the frame sync, or one bit period later.

The host owns a single data register. `data_free` tells it when that register can be refilled. If the register is not refilled in time, the last word is sent again. A frame sync that arrives while a frame is still running is handled according to `sync_ignore`:
- when `sync_ignore` is clear, the sync restarts the frame and sets a sticky error flag;
- when `sync_ignore` is set, the sync is dropped.

A single interrupt line reports one of two events, chosen by `irq_sel`: the data register becoming free, or a sync error.

The controlling state machine has four states:
- `ST_OFF`: disabled, `enable` low.
- `ST_WAIT`: enabled, between frames.
- `ST_DELAY`: the one-bit gap before the first data bit.
- `ST_SHIFT`: data bits going out.

Its transitions are:
- *enable*: `ST_OFF`→`ST_WAIT`.
- *disable*: any state→`ST_OFF`.
- *start*: `ST_WAIT`→`ST_DELAY` or `ST_SHIFT`, on an accepted sync.
- *gap done*: `ST_DELAY`→`ST_SHIFT`.
- *next bit*, *next word* and *next phase*: `ST_SHIFT`→`ST_SHIFT`.
- *restart*: `ST_DELAY` or `ST_SHIFT` → `ST_DELAY` or `ST_SHIFT`, on an early sync.
- *frame end*: `ST_SHIFT`→`ST_WAIT`.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `ser_out`=0, `sync_err`=0, `irq`=0 and `data_free`=1. While `enable` is low, `ser_out` stays 0, frame syncs are ignored, and `sync_err` reads 0 one clock after `enable` falls.
- R2: The word-length codes `wlen_a` and `wlen_b` map as follows: 0→8 bits, 1→12 bits, 2→16 bits, 3→20 bits, 4→24 bits, and 5, 6 or 7→32 bits. The low-order N bits of the written word are sent, most significant bit first, one bit per `bit_en` cycle.
- R3: A phase carries its count field plus one words (`wcnt_a`+1 or `wcnt_b`+1). With `dual_phase`=0 the frame is phase A alone.
- R4: With `dual_phase`=1, phase B (`wlen_b`, `wcnt_b`) follows phase A in the same frame.
- R5: Data delay. The frame sync is sampled on a `bit_en` clock edge. With `data_delay`=0 the MSB is on `ser_out` right after that edge. With `data_delay`=1, `ser_out` is 0 for one bit period and the MSB follows after the next `bit_en` edge.
- R6: A write (`wr_valid`) makes `data_free` low from the next clock. Each word load into the shifter makes it high again, unless a write arrives on the same edge; in that case the new data is kept and the loaded word is the old one.
- R7: If no write arrived since the last load, the next word due is a repeat of the previous word.
- R8: A sync sampled mid-frame with `sync_ignore`=0 sets `sync_err`. The flag stays set until `enable` goes low. The sync also restarts the frame from phase A with the current data register.
- R9: A sync sampled mid-frame with `sync_ignore`=1 has no effect on the stream and does not set `sync_err`.
- R10: A sync sampled on the edge that ends the final bit of a frame starts the next frame without error.
- R11: `irq_sel`=0 gives a one-clock `irq` pulse for each word load. `irq_sel`=1 gives a one-clock pulse for each sync error.
- R12: `ser_out` is 0 between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter run; low holds it idle and clears the error |
| bit_en | input | 1 | Bit-clock enable, one bit period per high cycle |
| fsync | input | 1 | Frame sync, active high, sampled when bit_en is high |
| wlen_a | input | 3 | Phase A word-length code |
| wlen_b | input | 3 | Phase B word-length code |
| wcnt_a | input | CNT_W | Phase A words minus one |
| wcnt_b | input | CNT_W | Phase B words minus one |
| dual_phase | input | 1 | 1 enables phase B |
| data_delay | input | 1 | 0 or 1 bit gap between sync and first bit |
| sync_ignore | input | 1 | 1 ignores syncs that arrive mid-frame |
| irq_sel | input | 1 | 0 irq on word load, 1 irq on sync error |
| wr_valid | input | 1 | Host write strobe for the data register |
| wr_data | input | DATA_W | Host write data |
| ser_out | output | 1 | Serial data |
| data_free | output | 1 | Data register may be written |
| sync_err | output | 1 | Sticky frame sync error |
| irq | output | 1 | Selected event pulse |

## Verification
A wrong bit or word counter shows up on `ser_out` within the frame it corrupts. It makes a word too long or too short, and the line is still high, or already low, at the sample just after the expected frame end. A stale phase bit appears as the wrong word length on the next phase change. A lost or stuck load strobe shows up within one word time as a `data_free` level that never rises, or as a data word that is not repeated when it should be. A wrong sync decision is visible in the cycle after the offending sync: the stream restarts when it should not, or fails to restart, and `sync_err` and `irq` follow on the same edge.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_SHIFT = 2'd3
    } tx_state_t;

    // Bits per word for a length code; codes above 4 select 32 bits.
    function automatic int unsigned wl_bits(input logic [2:0] code);
        unique case (code)
            3'd0:    return 8;
            3'd1:    return 12;
            3'd2:    return 16;
            3'd3:    return 20;
            3'd4:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/sftx_hold.sv
module sftx_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] word,
    output logic              free
);

    logic full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            full <= 1'b0;
        end else begin
            if (take)
                full <= 1'b0;
            if (wr_valid) begin
                word <= wr_data;
                full <= 1'b1;
            end
        end
    end

    assign free = ~full;

    // R6
    wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !free);

    // R6
    take_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !wr_valid |=> free);

endmodule

// File: rtl/sftx_fsm.sv
module sftx_fsm
    import sftx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 7,
    parameter int LEN_W  = $clog2(DATA_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bit_en,
    input  logic             fsync,
    input  logic [2:0]       wlen_a,
    input  logic [2:0]       wlen_b,
    input  logic [CNT_W-1:0] wcnt_a,
    input  logic [CNT_W-1:0] wcnt_b,
    input  logic             dual_phase,
    input  logic             data_delay,
    input  logic             sync_ignore,
    input  logic             irq_sel,
    output logic             take,
    output logic             shift,
    output logic [LEN_W-1:0] load_len,
    output logic             active,
    output logic             sync_err,
    output logic             irq
);

    localparam int BC_W = $clog2(DATA_W);

    tx_state_t        state, nxt;
    logic [BC_W-1:0]  bit_cnt, nxt_bit;
    logic [CNT_W-1:0] word_cnt, nxt_word;
    logic             phase, nxt_phase;
    logic             err_evt;
    logic [LEN_W-1:0] len_a, len_b;
    logic             mid, last_word, frame_end, start_ok, start_bad;

    assign len_a     = LEN_W'(wl_bits(wlen_a));
    assign len_b     = LEN_W'(wl_bits(wlen_b));
    assign mid       = (state == ST_DELAY) || (state == ST_SHIFT);
    assign last_word = (word_cnt == '0);
    assign frame_end = (state == ST_SHIFT) && (bit_cnt == '0) && last_word
                       && (phase || !dual_phase);
    assign start_ok  = fsync && ((state == ST_WAIT) || frame_end);
    assign start_bad = fsync && mid && !frame_end && !sync_ignore;

    // Next state, counters and strobes.
    always_comb begin
        nxt       = state;
        nxt_bit   = bit_cnt;
        nxt_word  = word_cnt;
        nxt_phase = phase;
        take      = 1'b0;
        shift     = 1'b0;
        err_evt   = 1'b0;
        load_len  = len_a;
        if (!enable) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: nxt = ST_WAIT;
                ST_WAIT, ST_DELAY, ST_SHIFT: begin
                    if (bit_en) begin
                        if (start_ok || start_bad) begin
                            take      = 1'b1;
                            err_evt   = start_bad;
                            load_len  = len_a;
                            nxt_phase = 1'b0;
                            nxt_word  = wcnt_a;
                            nxt_bit   = BC_W'(len_a - 1'b1);
                            nxt       = data_delay ? ST_DELAY : ST_SHIFT;
                        end else if (state == ST_DELAY) begin
                            nxt = ST_SHIFT;
                        end else if (state == ST_SHIFT) begin
                            if (bit_cnt != '0) begin
                                shift   = 1'b1;
                                nxt_bit = bit_cnt - 1'b1;
                            end else if (!last_word) begin
                                take     = 1'b1;
                                load_len = phase ? len_b : len_a;
                                nxt_word = word_cnt - 1'b1;
                                nxt_bit  = BC_W'(load_len - 1'b1);
                            end else if (!phase && dual_phase) begin
                                take      = 1'b1;
                                load_len  = len_b;
                                nxt_phase = 1'b1;
                                nxt_word  = wcnt_b;
                                nxt_bit   = BC_W'(len_b - 1'b1);
                            end else begin
                                nxt = ST_WAIT;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            bit_cnt  <= '0;
            word_cnt <= '0;
            phase    <= 1'b0;
        end else begin
            state    <= nxt;
            bit_cnt  <= nxt_bit;
            word_cnt <= nxt_word;
            phase    <= nxt_phase;
        end
    end

    // Flag and event outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_err <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= irq_sel ? err_evt : take;
            if (!enable)
                sync_err <= 1'b0;
            else if (err_evt)
                sync_err <= 1'b1;
        end
    end

    assign active = (state == ST_SHIFT);

    // R1
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sync_err);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err && enable |=> sync_err);

    // R9
    ignore_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && fsync && sync_ignore && sync_err == 1'b0 |=> !sync_err);

    // R2
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en && enable && state != ST_OFF |=> $stable(state) && $stable(bit_cnt));

endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              shift,
    input  logic [DATA_W-1:0] word,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              active,
    output logic              ser
);

    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (take)
            shreg <= word << (DATA_W - int'(load_len));
        else if (shift)
            shreg <= {shreg[DATA_W-2:0], 1'b0};
    end

    assign ser = active & shreg[DATA_W-1];

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic [2:0]        wlen_a,
    input  logic [2:0]        wlen_b,
    input  logic [CNT_W-1:0]  wcnt_a,
    input  logic [CNT_W-1:0]  wcnt_b,
    input  logic              dual_phase,
    input  logic              data_delay,
    input  logic              sync_ignore,
    input  logic              irq_sel,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ser_out,
    output logic              data_free,
    output logic              sync_err,
    output logic              irq
);

    localparam int LEN_W = $clog2(DATA_W) + 1;

    logic              take, shift, active;
    logic [LEN_W-1:0]  load_len;
    logic [DATA_W-1:0] word;

    sftx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .word     (word),
        .free     (data_free)
    );

    sftx_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .bit_en      (bit_en),
        .fsync       (fsync),
        .wlen_a      (wlen_a),
        .wlen_b      (wlen_b),
        .wcnt_a      (wcnt_a),
        .wcnt_b      (wcnt_b),
        .dual_phase  (dual_phase),
        .data_delay  (data_delay),
        .sync_ignore (sync_ignore),
        .irq_sel     (irq_sel),
        .take        (take),
        .shift       (shift),
        .load_len    (load_len),
        .active      (active),
        .sync_err    (sync_err),
        .irq         (irq)
    );

    sftx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .shift    (shift),
        .word     (word),
        .load_len (load_len),
        .active   (active),
        .ser      (ser_out)
    );

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !ser_out);

endmodule

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, bit_en = 1'b0, fsync = 1'b0;
    logic [2:0]  wlen_a = '0, wlen_b = '0;
    logic [6:0]  wcnt_a = '0, wcnt_b = '0;
    logic        dual_phase = 1'b0, data_delay = 1'b0, sync_ignore = 1'b0, irq_sel = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ser_out, data_free, sync_err, irq;

    int checks = 0, errors = 0, irq_seen = 0;
    logic [31:0] feed [4];
    int feed_n = 0, feed_i = 0;
    logic [63:0] got;
    logic tail;

    always #5 clk = ~clk;

    serial_frame_tx i_serial_frame_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_en(bit_en), .fsync(fsync),
        .wlen_a(wlen_a), .wlen_b(wlen_b), .wcnt_a(wcnt_a), .wcnt_b(wcnt_b),
        .dual_phase(dual_phase), .data_delay(data_delay), .sync_ignore(sync_ignore),
        .irq_sel(irq_sel), .wr_valid(wr_valid), .wr_data(wr_data),
        .ser_out(ser_out), .data_free(data_free), .sync_err(sync_err), .irq(irq)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] wa, input logic [6:0] ca, input logic [2:0] wb,
                           input logic [6:0] cb, input logic dual, input logic dly,
                           input logic ign, input logic isel);
        @(negedge clk);
        wlen_a = wa; wcnt_a = ca; wlen_b = wb; wcnt_b = cb;
        dual_phase = dual; data_delay = dly; sync_ignore = ign; irq_sel = isel;
    endtask

    task automatic preload(input logic [31:0] d);
        @(negedge clk); wr_data = d; wr_valid = 1'b1;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    // Sync sampled at edge E; bit i sampled at the negedge after edge E+i.
    task automatic frame_run(input int nbits, input int sync_at);
        got = '0; irq_seen = 0; feed_i = 0;
        @(negedge clk); fsync = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            fsync = (i == sync_at);
            got = {got[62:0], ser_out};
            if (irq) irq_seen++;
            wr_valid = 1'b0;
            if (data_free && feed_i < feed_n) begin
                wr_data = feed[feed_i]; wr_valid = 1'b1; feed_i++;
            end
        end
        @(negedge clk);
        fsync = 1'b0; wr_valid = 1'b0;
        tail = ser_out;
        if (irq) irq_seen++;
        feed_n = 0;
    endtask

    task automatic t_reset;
        chk("R1 reset ser_out", 64'(ser_out), 64'd0);
        chk("R1 reset data_free", 64'(data_free), 64'd1);
        chk("R1 reset sync_err", 64'(sync_err), 64'd0);
        chk("R1 reset irq", 64'(irq), 64'd0);
    endtask

    task automatic t_single;
        set_cfg(3'd0, 7'd1, 3'd0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        preload(32'h1A5);
        chk("R6 busy after write", 64'(data_free), 64'd0);
        feed[0] = 32'h3C; feed_n = 1;
        frame_run(16, -1);
        chk("R3 two 8-bit words", got, 64'hA53C);
        chk("R12 low after frame", 64'(tail), 64'd0);
        chk("R11 load irq pulses", 64'(irq_seen), 64'd2);
        chk("R6 free after load", 64'(data_free), 64'd1);
    endtask

    task automatic t_delay;
        set_cfg(3'd0, 7'd0, 3'd0, 7'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        preload(32'h81);
        frame_run(9, -1);
        chk("R5 one bit delay", got, 64'h081);
        chk("R12 low after delayed frame", 64'(tail), 64'd0);
    endtask

    task automatic t_dual;
        set_cfg(3'd2, 7'd0, 3'd0, 7'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        preload(32'h1234);
        feed[0] = 32'hC3; feed_n = 1;
        frame_run(24, -1);
        chk("R4 dual phase 16+8", got, 64'h1234C3);
        chk("R4 frame end", 64'(tail), 64'd0);
    endtask

    task automatic t_underrun;
        set_cfg(3'd0, 7'd2, 3'd0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        preload(32'h5A);
        frame_run(24, -1);
        chk("R7 repeated word", got, 64'h5A5A5A);
    endtask

    task automatic t_lengths;
        logic [2:0] codes [4] = '{3'd1, 3'd3, 3'd4, 3'd5};
        int lens [4] = '{12, 20, 24, 32};
        for (int k = 0; k < 4; k++) begin
            set_cfg(codes[k], 7'd0, 3'd0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0);
            preload(32'hFFFF_FFFF);
            frame_run(lens[k], -1);
            chk($sformatf("R2 length code %0d ones", codes[k]), got, (64'd1 << lens[k]) - 1);
            chk($sformatf("R2 length code %0d end", codes[k]), 64'(tail), 64'd0);
        end
    endtask

    task automatic t_sync_err;
        set_cfg(3'd0, 7'd1, 3'd0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        preload(32'hF0);
        frame_run(20, 3);
        chk("R8 restart stream", got, 64'hFF0F0);
        chk("R8 sticky error", 64'(sync_err), 64'd1);
        chk("R11 error irq pulse", 64'(irq_seen), 64'd1);
    endtask

    task automatic t_disable;
        @(negedge clk); enable = 1'b0; fsync = 1'b1; bit_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 disabled line low", 64'(ser_out), 64'd0);
        end
        chk("R1 error cleared", 64'(sync_err), 64'd0);
        fsync = 1'b0; enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_ignore;
        set_cfg(3'd0, 7'd1, 3'd0, 7'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        preload(32'hF0);
        frame_run(16, 3);
        chk("R9 stream unchanged", got, 64'hF0F0);
        chk("R9 no error", 64'(sync_err), 64'd0);
        chk("R9 no irq", 64'(irq_seen), 64'd0);
    endtask

    task automatic t_back2back;
        set_cfg(3'd0, 7'd0, 3'd0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        preload(32'h99);
        feed[0] = 32'h66; feed_n = 1;
        frame_run(16, 7);
        chk("R10 consecutive frames", got, 64'h9966);
        chk("R10 no error", 64'(sync_err), 64'd0);
        chk("R10 line low after", 64'(tail), 64'd0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        enable = 1'b1; bit_en = 1'b1;
        @(negedge clk);
        t_single();
        t_delay();
        t_dual();
        t_underrun();
        t_lengths();
        t_sync_err();
        t_disable();
        t_ignore();
        t_back2back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule